// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous SRAM

This block is a single-port synchronous static memory for cache and buffer storage. Its bus splits into separate write-data and read-data paths, plus a drive flag that says when the read path would own a shared data bus. Address and controls are captured on a rising clock edge. A read returns its word from an output register one full cycle after capture. A write takes its data one edge after the command, so a write can follow a write every cycle with no gap on the bus.

Accepted write data is held in a pending register. It reaches the array only when the next write's data arrives. Any read that targets the pending address takes the pending lanes from the register and the other lanes from the array. Writes are masked per 9-bit lane. An asynchronous output enable and an asynchronous sleep input can stop the drive at any time. A protocol flag reports a write that follows a read without the idle cycle needed to turn the bus around.

Top module: `lwsram_top`

## Requirements
- R1: While rstN is low, and after its release until a read completes, rdrvEn is 0, rdata is 0 and turnErr is 0.
- R2: A read command (csN=0, weN=1, sleep=0) captured at edge k makes the addressed word appear on rdata, with rdrvEn=1 when oeN=0, during the cycle after edge k+1 and for that cycle only.
- R3: For a write command (csN=0, weN=0) captured at edge k, the data written is the value of wdata sampled at edge k+1.
- R4: The word is four 9-bit lanes, lane i being bits [9i+8:9i]. A lane is written only when laneWeN[i]=0 during a write command. Lanes whose enable is 1 keep their old contents.
- R5: A read issued right after a write, or after partial writes to the same word, returns the byte-merged latest data and never stale array contents.
- R6: A write with laneWeN=4'b1111 changes nothing: neither the addressed word nor an earlier write still pending.
- R7: With csN=1 a command has no effect, whatever weN and laneWeN are.
- R8: oeN=1 forces rdrvEn to 0 and rdata to 0 at once, with no clock edge. Restoring oeN=0 restores the registered read word at once.
- R9: sleep=1 at once forces rdrvEn and rdata to 0. Commands captured while it is high are ignored, and a write whose data edge falls in sleep is dropped.
- R10: turnErr is 1 for exactly the cycle after an edge that captures a write command when the preceding edge captured a read. A write separated from the read by an idle cycle leaves turnErr at 0.
- R11: The depth is the DEPTH parameter, the address width is its base-2 logarithm, and the word at address DEPTH-1 stores and reads back like any other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset of the control and pipeline registers |
| addr | input | AW | Word address, captured with the command |
| csN | input | 1 | Active-low chip select, sampled at the edge |
| weN | input | 1 | Active-low write command, sampled at the edge |
| laneWeN | input | 4 | Active-low per-lane write enables, sampled with the command |
| wdata | input | 36 | Write data, sampled one edge after the write command |
| oeN | input | 1 | Active-low asynchronous output enable |
| sleep | input | 1 | Active-high asynchronous sleep |
| rdata | output | 36 | Registered read word, 0 whenever not driven |
| rdrvEn | output | 1 | High while the read word is being driven |
| turnErr | output | 1 | One-cycle pulse for a write with no idle cycle after a read |

## Verification
A read is due two edges after the bench drives it. The edge that follows the drive captures the command, and the next edge loads the output register. The driver stores each expected word together with the cycle count two ahead, and the monitor compares that entry at the falling edge of exactly that cycle. Write data is presented one cycle after the write command. turnErr is sampled at the falling edge right after the edge that captures the offending write. The oeN and sleep checks are made a time step after each change, inside a cycle, with no clock edge between.

// File: rtl/lwsram_pkg.sv
package lwsram_pkg;
  parameter int LANES  = 4;
  parameter int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;

  typedef logic [LANES-1:0]  laneMask_t;
  typedef logic [WORD_W-1:0] word_t;

  // strobes from control to datapath
  typedef struct packed {
    logic      capAddr;  // command accepted this edge: capture address
    logic      rdFetch;  // read captured last edge: load output register
    logic      wrLoad;   // write captured last edge: take data into pending
    laneMask_t wrMask;   // active-high lanes of that write
  } strobes_t;
endpackage

// File: rtl/lwsram_ctrl.sv
module lwsram_ctrl
  import lwsram_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      csN,
  input  logic      weN,
  input  laneMask_t laneWeN,
  input  logic      sleep,
  output strobes_t  strb,
  output logic      turnErr
);
  logic      accept;
  logic      rdPend;
  logic      wrPend;
  laneMask_t wrMaskQ;
  logic      turnErrQ;

  assign accept = !csN && !sleep;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPend   <= 1'b0;
      wrPend   <= 1'b0;
      wrMaskQ  <= '0;
      turnErrQ <= 1'b0;
    end else begin
      rdPend   <= accept && weN;
      wrPend   <= accept && !weN && (laneWeN != {LANES{1'b1}});
      wrMaskQ  <= ~laneWeN;
      turnErrQ <= accept && !weN && rdPend;
    end
  end

  always_comb begin
    strb.capAddr = accept;
    strb.rdFetch = rdPend;
    strb.wrLoad  = wrPend && !sleep;
    strb.wrMask  = wrMaskQ;
  end

  assign turnErr = turnErrQ;

  // R6: a write with every lane disabled never loads the pending register
  p_noop_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !sleep && !weN && (laneWeN == {LANES{1'b1}})) |=> !strb.wrLoad);

  // R9: nothing captured during sleep takes effect
  p_sleep_blocks_r9: assert property (@(posedge clk) disable iff (!rstN)
    sleep |=> (!strb.rdFetch && !strb.wrLoad));

  // R10: the protocol flag never lasts two cycles
  p_turn_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    turnErr |=> !turnErr);

  // R4: a loaded write always carries at least one lane
  p_mask_live_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrLoad |-> (strb.wrMask != '0));
endmodule

// File: rtl/lwsram_dpath.sv
module lwsram_dpath
  import lwsram_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] addr,
  input  word_t         wdata,
  input  strobes_t      strb,
  input  logic          oeN,
  input  logic          sleep,
  output word_t         rdata,
  output logic          rdrvEn
);
  word_t         mem [DEPTH];
  logic [AW-1:0] addrQ;

  logic          pendValid;
  logic [AW-1:0] pendAddr;
  word_t         pendData;
  laneMask_t     pendMask;

  word_t         arrWord;
  word_t         fwdWord;
  logic          pendHit;
  laneMask_t     hitLane;

  word_t         outQ;
  logic          outValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) addrQ <= '0;
    else if (strb.capAddr) addrQ <= addr;
  end

  // pending write: newest data waits here until the next write's data arrives
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendAddr  <= '0;
      pendData  <= '0;
      pendMask  <= '0;
    end else if (strb.wrLoad) begin
      pendValid <= 1'b1;
      pendAddr  <= addrQ;
      pendData  <= wdata;
      pendMask  <= strb.wrMask;
    end
  end

  // commit of the older pending write, lane by lane
  always_ff @(posedge clk) begin
    if (strb.wrLoad && pendValid) begin
      for (int i = 0; i < LANES; i++) begin
        if (pendMask[i]) mem[pendAddr][i*LANE_W +: LANE_W] <= pendData[i*LANE_W +: LANE_W];
      end
    end
  end

  assign arrWord = mem[addrQ];
  assign pendHit = pendValid && (pendAddr == addrQ);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign hitLane[g] = pendHit && pendMask[g];
    assign fwdWord[g*LANE_W +: LANE_W] = hitLane[g] ? pendData[g*LANE_W +: LANE_W]
                                                    : arrWord[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outQ     <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= strb.rdFetch;
      if (strb.rdFetch) outQ <= fwdWord;
    end
  end

  assign rdrvEn = outValid && !oeN && !sleep;
  assign rdata  = rdrvEn ? outQ : '0;

  // R2: the drive is only ever the result of a fetch one edge earlier
  p_drive_after_fetch_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdrvEn |-> $past(strb.rdFetch));

  // R6: pending write is untouched by anything but a loaded write
  p_pend_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrLoad |=> ($stable(pendValid) && $stable(pendAddr) && $stable(pendData)));

  // R3: after a data edge a pending write is always held
  p_pend_after_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrLoad |=> pendValid);
endmodule

// File: rtl/lwsram_top.sv
module lwsram_top
  import lwsram_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [AW-1:0]     addr,
  input  logic              csN,
  input  logic              weN,
  input  logic [LANES-1:0]  laneWeN,
  input  logic [WORD_W-1:0] wdata,
  input  logic              oeN,
  input  logic              sleep,
  output logic [WORD_W-1:0] rdata,
  output logic              rdrvEn,
  output logic              turnErr
);
  strobes_t strb;

  lwsram_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .csN     (csN),
    .weN     (weN),
    .laneWeN (laneWeN),
    .sleep   (sleep),
    .strb    (strb),
    .turnErr (turnErr)
  );

  lwsram_dpath #(.DEPTH(DEPTH), .AW(AW)) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .addr   (addr),
    .wdata  (wdata),
    .strb   (strb),
    .oeN    (oeN),
    .sleep  (sleep),
    .rdata  (rdata),
    .rdrvEn (rdrvEn)
  );
endmodule

// File: tb/sim_lwsram_top.sv
module sim_lwsram_top;
  import lwsram_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;
  localparam int AW = $clog2(DEPTH);
  localparam int K_IDLE = 0, K_RD = 1, K_WR = 2, K_DESEL = 3, K_RDX = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [AW-1:0] addr = '0;
  logic csN = 1'b1, weN = 1'b1, oeN = 1'b0, sleep = 1'b0;
  logic [LANES-1:0] laneWeN = '1;
  logic [WORD_W-1:0] wdata = '0;
  logic [WORD_W-1:0] rdata;
  logic rdrvEn, turnErr;

  lwsram_top #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rstN(rstN), .addr(addr), .csN(csN), .weN(weN), .laneWeN(laneWeN),
    .wdata(wdata), .oeN(oeN), .sleep(sleep), .rdata(rdata), .rdrvEn(rdrvEn), .turnErr(turnErr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;

  typedef struct { int due; logic [WORD_W-1:0] val; string req; } exp_t;
  exp_t expQ[$];
  logic [WORD_W-1:0] model [DEPTH];
  logic [WORD_W-1:0] nextData = '0;

  task automatic chk(input bit ok, input string req, input logic [WORD_W-1:0] act,
                     input logic [WORD_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic logic [WORD_W-1:0] merge(input logic [WORD_W-1:0] old,
      input logic [WORD_W-1:0] d, input logic [LANES-1:0] en);
    logic [WORD_W-1:0] r = old;
    for (int i = 0; i < LANES; i++)
      if (en[i]) r[i*LANE_W +: LANE_W] = d[i*LANE_W +: LANE_W];
    return r;
  endfunction

  // driver: one command per cycle, write data follows one cycle later
  task automatic step(input int kind, input int a, input logic [LANES-1:0] en,
                      input logic [WORD_W-1:0] d, input string req);
    csN     = (kind == K_IDLE) || (kind == K_DESEL);
    weN     = !((kind == K_WR) || (kind == K_DESEL));
    laneWeN = ~en;
    addr    = AW'(a);
    wdata   = nextData;
    nextData = ((kind == K_WR) || (kind == K_DESEL)) ? d : '0;
    if (kind == K_RD && !sleep) expQ.push_back('{cyc + 2, model[a], req});
    if (kind == K_WR && !sleep) model[a] = merge(model[a], d, en);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(K_IDLE, 0, '0, '0, "");
  endtask

  // monitor: compares queued reads exactly in their due cycle
  always @(negedge clk) begin
    while (expQ.size() > 0 && expQ[0].due <= cyc) begin
      if (expQ[0].due < cyc) chk(1'b0, {expQ[0].req, " missed"}, rdata, expQ[0].val);
      else chk(rdrvEn && (rdata == expQ[0].val), expQ[0].req, rdata, expQ[0].val);
      void'(expQ.pop_front());
    end
  end

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    finishRun();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!rdrvEn && rdata == '0, "R1 drive", {35'b0, rdrvEn}, '0);
    chk(!turnErr, "R1 turnErr", {35'b0, turnErr}, '0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!rdrvEn && !turnErr, "R1 after release", {34'b0, turnErr, rdrvEn}, '0);

    // R3 fill with full-word writes, back to back
    for (int i = 0; i < 16; i++)
      step(K_WR, i, 4'hF, {4'(i), 32'h1234_5678 ^ (32'(i) * 32'h0101_0101)}, "R3");
    idle(1);
    // R2 read back stream
    for (int i = 0; i < 16; i++) step(K_RD, i, '0, '0, "R2/R3");
    idle(2);

    // R4 partial lane writes
    step(K_WR, 3, 4'b0101, 36'hA_BBCC_DDEE, "R4");
    step(K_WR, 5, 4'b1000, 36'h5_5555_5555, "R4");
    idle(1);
    step(K_RD, 3, '0, '0, "R4");
    step(K_RD, 5, '0, '0, "R4");
    idle(2);

    // R5 read directly after write, and stacked partial writes
    step(K_WR, 7, 4'b0010, 36'h0_0000_7F00 | 36'h1_0203_0405, "R5");
    step(K_RD, 7, '0, '0, "R5 forward");
    idle(1);
    step(K_WR, 8, 4'hF, 36'h1_1111_1111, "R5");
    step(K_WR, 8, 4'b0001, 36'hF_FFFF_FFFF, "R5");
    step(K_RD, 8, '0, '0, "R5 merge");
    idle(1);
    step(K_WR, 8, 4'b0100, 36'h0_0C00_0000 | 36'h0_0000_0123, "R5");
    idle(1);
    step(K_RD, 8, '0, '0, "R5 pending");
    idle(2);

    // R6 no-lane write leaves pending and array alone
    step(K_WR, 9, 4'hF, 36'h9_9999_9999, "R6");
    step(K_WR, 10, 4'h0, 36'hE_EEEE_EEEE, "R6");
    step(K_RD, 9, '0, '0, "R6 pending kept");
    step(K_RD, 10, '0, '0, "R6 word kept");
    idle(2);

    // R7 deselected write
    step(K_DESEL, 11, 4'hF, 36'hD_DDDD_DDDD, "R7");
    idle(1);
    step(K_RD, 11, '0, '0, "R7");
    idle(2);

    // R11 top address
    step(K_WR, DEPTH-1, 4'hF, 36'h7_0F0F_0F0F, "R11");
    step(K_WR, 0, 4'hF, 36'h2_2222_2222, "R11");
    idle(1);
    step(K_RD, DEPTH-1, '0, '0, "R11");
    step(K_RD, 0, '0, '0, "R11");
    idle(3);

    // R10 missing dead cycle
    step(K_RD, 1, '0, '0, "R10 read");
    step(K_WR, 2, 4'hF, 36'h3_3333_3333, "R10");
    chk(turnErr, "R10 pulse", {35'b0, turnErr}, 36'd1);
    idle(1);
    chk(!turnErr, "R10 one cycle", {35'b0, turnErr}, '0);
    step(K_RD, 1, '0, '0, "R10 read");
    idle(1);
    step(K_WR, 2, 4'hF, 36'h4_4444_4444, "R10");
    chk(!turnErr, "R10 gap ok", {35'b0, turnErr}, '0);
    idle(3);

    // R8 asynchronous output enable
    step(K_RDX, 4, '0, '0, "");
    idle(1);
    #1 oeN = 1'b1;
    #1 chk(!rdrvEn && rdata == '0, "R8 off", rdata, '0);
    oeN = 1'b0;
    #1 chk(rdrvEn && rdata == model[4], "R8 on", rdata, model[4]);
    idle(2);

    // R9 asynchronous sleep on the drive
    step(K_RDX, 4, '0, '0, "");
    idle(1);
    #1 sleep = 1'b1;
    #1 chk(!rdrvEn && rdata == '0, "R9 undrive", rdata, '0);
    sleep = 1'b0;
    #1 chk(rdrvEn && rdata == model[4], "R9 wake", rdata, model[4]);
    idle(2);

    // R9 commands ignored in sleep
    sleep = 1'b1;
    step(K_WR, 6, 4'hF, 36'h6_DEAD_BEEF, "R9");
    step(K_RD, 6, '0, '0, "R9");
    idle(1);
    sleep = 1'b0;
    idle(1);
    chk(!rdrvEn, "R9 read ignored", {35'b0, rdrvEn}, '0);
    step(K_RD, 6, '0, '0, "R9 write dropped");
    idle(4);

    chk(expQ.size() == 0, "R2 queue drained", 36'(expQ.size()), '0);
    finishRun();
  end
endmodule